// File: doc/BRIEF.md
# Self-timed three-wire bus master

This block is the initiating node on a three-line, delay-insensitive bus. At rest, exactly one of the lines A, B or C is asserted; that line is the idle line. The node carries one bit per step. It moves the bus away from the idle line to one of the other two lines. It then waits until every follower has let go of the old line before it counts the bit as delivered. No fixed bit time exists. Each bit takes as long as the slowest follower needs.

The node can also give up the bus and become a follower. As a follower it tracks every transition that other nodes make, so it always knows the current idle line. It can take the bus back through a fixed rotation of lines, either on request or when a follower asks for service. The line inputs are the resolved bus levels (1 = asserted) and pass through a synchroniser first. The node drives its own assert enables for the three lines.

Top module: `tri_line_master`

## Requirements
- R1: The node drives exactly one line in every cycle. After reset it drives only line A (drive_o = 3'b001, bit 0 = A, bit 1 = B, bit 2 = C), master_o is high, and busy_o and bit_ready_o are low.
- R2: A master in an idle state with idle line i that accepts a request bit_valid_i drives only line (i+1) mod 3 for a one and only line (i+2) mod 3 for a zero. It releases line i in the same cycle.
- R3: bit_ready_o goes high for exactly one cycle, SYNC_STAGES cycles after the last node releases the old idle line. Until then drive_o holds and busy_o is high. Afterwards busy_o is low.
- R4: Line roles rotate with the idle line. After a series of bits, the idle line is the start line plus one for each one and two for each zero, modulo 3.
- R5: bit_valid_i has no effect unless the node is master and idle. As a follower, drive_o is unchanged by it and bit_ready_o stays low.
- R6: handover_i in the master idle state with idle line i makes the node drive only line (i+1) mod 3, and master_o falls in the same cycle.
- R7: A follower with idle line i that sees another line asserted drives only that line and releases i. The new line becomes its idle line once i is seen released.
- R8: A follower with idle line i and claim_i high that sees line (i+1) asserted drives only line (i+2). Once (i+2) is the only line asserted, it drives only line i. master_o rises only after line i is seen alone.
- R9: A master idle on line i that sees line (i+1) asserted by another node runs the R8 take sequence and ends as master on line i. This takes priority over handover_i and bit_valid_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 3 | Resolved bus levels, 1 = asserted (bit 0 = A) |
| bit_valid_i | input | 1 | Bit offered for transmission |
| bit_data_i | input | 1 | Bit value, held while bit_valid_i is high |
| handover_i | input | 1 | Give up the bus from the master idle state |
| claim_i | input | 1 | Take the bus when another node starts a handover |
| drive_o | output | 3 | Line assert enables of this node |
| bit_ready_o | output | 1 | Bit accepted; pulses when its transfer completes |
| master_o | output | 1 | Node currently holds the bus |
| busy_o | output | 1 | Node is between idle states |

## Verification
The assertions assume that the other nodes keep to the protocol. Only one foreign transition appears at a time, the bus never sits with all lines released, and bit_data_i stays stable while bit_valid_i is high. They also assume claim_i is raised only when the bus owner is about to hand over, because a follower cannot tell a handover start from a one bit. The bench stays inside these limits. Its follower model only moves to a new line after the old one clears. The scripted remote node steps through each handover or bit only after the bus has settled from the previous step. The bench also holds bit_data_i with bit_valid_i until the accept pulse.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  localparam int unsigned NLINES = 3;
  localparam int unsigned IDX_W  = 2;

  typedef logic [NLINES-1:0] lines_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // relative line views: 0 = idle line, 1 = next, 2 = after next
  localparam lines_t REL0 = 3'b001;
  localparam lines_t REL1 = 3'b010;
  localparam lines_t REL2 = 3'b100;

  typedef enum logic [2:0] {
    ST_M_IDLE,
    ST_M_SEND,
    ST_F_IDLE,
    ST_F_MOVE,
    ST_T_CROSS,
    ST_T_CLOSE
  } state_e;

  function automatic idx_t idx_add(input idx_t a, input idx_t b);
    logic [IDX_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (IDX_W+1)'(NLINES)) s = s - (IDX_W+1)'(NLINES);
    return s[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/tlm_line_sync.sv
module tlm_line_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tlm_rotor.sv
module tlm_rotor
  import tlm_pkg::*;
(
  input  idx_t   cur_i,
  input  lines_t abs_lines_i,
  input  lines_t rel_drive_i,
  output lines_t rel_lines_o,
  output lines_t abs_drive_o
);
  for (genvar k = 0; k < NLINES; k++) begin : g_view
    idx_t pos_w;
    assign pos_w = idx_add(cur_i, idx_t'(k));
    assign rel_lines_o[k] = abs_lines_i[pos_w];
  end

  always_comb begin
    abs_drive_o = '0;
    for (int k = 0; k < NLINES; k++)
      abs_drive_o[idx_add(cur_i, idx_t'(k))] = rel_drive_i[k];
  end
endmodule

// File: rtl/tlm_ctrl.sv
module tlm_ctrl
  import tlm_pkg::*;
#(
  parameter bit INIT_MASTER = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  lines_t rel_i,
  input  logic   bit_valid_i,
  input  logic   bit_data_i,
  input  logic   handover_i,
  input  logic   claim_i,
  output lines_t rel_drive_o,
  output idx_t   cur_o,
  output logic   ready_o,
  output logic   master_o,
  output logic   busy_o
);
  localparam state_e RST_ST = INIT_MASTER ? ST_M_IDLE : ST_F_IDLE;

  state_e st_q, st_d;
  idx_t   cur_q, cur_d, tgt_q, tgt_d;
  lines_t drv_q, drv_d;
  logic   foreign;

  // in master idle only REL0 is ours, so REL1 comes from another node
  assign foreign = rel_i[1];

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    tgt_d = tgt_q;
    drv_d = drv_q;
    unique case (st_q)
      ST_M_IDLE: begin
        if (foreign) begin
          drv_d = REL2;
          st_d  = ST_T_CROSS;
        end else if (handover_i) begin
          drv_d = REL1;
          tgt_d = idx_t'(1);
          st_d  = ST_F_MOVE;
        end else if (bit_valid_i) begin
          drv_d = bit_data_i ? REL1 : REL2;
          tgt_d = bit_data_i ? idx_t'(1) : idx_t'(2);
          st_d  = ST_M_SEND;
        end
      end
      ST_M_SEND, ST_F_MOVE: begin
        if (!rel_i[0]) begin
          cur_d = idx_add(cur_q, tgt_q);
          drv_d = REL0;
          st_d  = (st_q == ST_M_SEND) ? ST_M_IDLE : ST_F_IDLE;
        end
      end
      ST_F_IDLE: begin
        if (rel_i[1]) begin
          drv_d = claim_i ? REL2 : REL1;
          tgt_d = idx_t'(1);
          st_d  = claim_i ? ST_T_CROSS : ST_F_MOVE;
        end else if (rel_i[2]) begin
          drv_d = REL2;
          tgt_d = idx_t'(2);
          st_d  = ST_F_MOVE;
        end
      end
      ST_T_CROSS: begin
        if (rel_i == REL2) begin
          drv_d = REL0;
          st_d  = ST_T_CLOSE;
        end
      end
      ST_T_CLOSE: begin
        if (rel_i == REL0) st_d = ST_M_IDLE;
      end
      default: st_d = ST_F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RST_ST;
      cur_q <= '0;
      tgt_q <= '0;
      drv_q <= REL0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      tgt_q <= tgt_d;
      drv_q <= drv_d;
    end
  end

  assign rel_drive_o = drv_q;
  assign cur_o       = cur_q;
  assign ready_o     = (st_q == ST_M_SEND) && !rel_i[0];
  assign master_o    = (st_q == ST_M_IDLE) || (st_q == ST_M_SEND);
  assign busy_o      = (st_q != ST_M_IDLE) && (st_q != ST_F_IDLE);

  AST_SEND_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_M_IDLE && !foreign && !handover_i && bit_valid_i)
      |=> (drv_q == ($past(bit_data_i) ? REL1 : REL2))); // R2
  AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_M_SEND && rel_i[0]) |=> ($stable(drv_q) && $stable(cur_q))); // R3
  AST_READY_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (master_o && !busy_o)); // R3
  AST_CUR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q != idx_t'(3)); // R4
  AST_NO_READY_FOLLOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_o |-> !ready_o); // R5
  AST_GIVE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_M_IDLE && !foreign && handover_i) |=> (!master_o && drv_q == REL1)); // R6
  AST_FOLLOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_F_IDLE && !rel_i[1] && rel_i[2]) |=> (drv_q == REL2 && !master_o)); // R7
  AST_MASTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(master_o) |-> $past(rel_i == REL0)); // R8
  AST_SERVICE_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_M_IDLE && foreign) |=> (drv_q == REL2 && !master_o)); // R9
endmodule

// File: rtl/tri_line_master.sv
module tri_line_master
  import tlm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          INIT_MASTER = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] line_i,
  input  logic              bit_valid_i,
  input  logic              bit_data_i,
  input  logic              handover_i,
  input  logic              claim_i,
  output logic [NLINES-1:0] drive_o,
  output logic              bit_ready_o,
  output logic              master_o,
  output logic              busy_o
);
  lines_t line_sync, rel_lines, rel_drive;
  idx_t   cur;

  tlm_line_sync #(
    .WIDTH  (NLINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(REL0)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_sync)
  );

  tlm_rotor u_rotor (
    .cur_i      (cur),
    .abs_lines_i(line_sync),
    .rel_drive_i(rel_drive),
    .rel_lines_o(rel_lines),
    .abs_drive_o(drive_o)
  );

  tlm_ctrl #(
    .INIT_MASTER(INIT_MASTER)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rel_i      (rel_lines),
    .bit_valid_i(bit_valid_i),
    .bit_data_i (bit_data_i),
    .handover_i (handover_i),
    .claim_i    (claim_i),
    .rel_drive_o(rel_drive),
    .cur_o      (cur),
    .ready_o    (bit_ready_o),
    .master_o   (master_o),
    .busy_o     (busy_o)
  );

  AST_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(drive_o)); // R1
endmodule

// File: tb/tri_line_master_tb.sv
module tri_line_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  // {bit, follower lag[2:0]}
  localparam logic [3:0] VEC_TBL [8] = '{
    4'b1_000, 4'b1_001, 4'b0_000, 4'b0_011,
    4'b1_101, 4'b1_010, 4'b0_110, 4'b1_000
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_valid = 1'b0, bit_data = 1'b0, handover = 1'b0, claim = 1'b0;
  logic [2:0] fol_drv = 3'b001, rm_drv = 3'b000, lines, drive_o;
  logic       bit_ready_o, master_o, busy_o;
  int         n_chk = 0, n_err = 0;
  int         fol_lag = 0, f_cur = 0, f_n1, f_n2, f_nx, f_old;
  int         cur;
  logic       done = 1'b0;

  assign lines = drive_o | fol_drv | rm_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_line_master u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .line_i     (lines),
    .bit_valid_i(bit_valid),
    .bit_data_i (bit_data),
    .handover_i (handover),
    .claim_i    (claim),
    .drive_o    (drive_o),
    .bit_ready_o(bit_ready_o),
    .master_o   (master_o),
    .busy_o     (busy_o)
  );

  function automatic logic [2:0] onehot(input int i);
    logic [2:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // follower model: follows any other line, settles once the old line clears
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        f_n1 = (f_cur + 1) % 3;
        f_n2 = (f_cur + 2) % 3;
        if (lines[f_n1] || lines[f_n2]) begin
          f_nx = lines[f_n1] ? f_n1 : f_n2;
          repeat (fol_lag) @(negedge clk);
          f_old   = f_cur;
          fol_drv = onehot(f_nx);
          f_cur   = f_nx;
          while (lines[f_old]) @(negedge clk);
        end
      end
    end
  end

  task automatic send_bit(input logic b, input int lag);
    int n, k;
    n = b ? (cur + 1) % 3 : (cur + 2) % 3;
    fol_lag = lag;
    bit_valid = 1'b1;
    bit_data = b;
    @(negedge clk);
    chk("R2 line on launch", 32'(drive_o), 32'(onehot(n)));
    chk("R3 busy in transfer", 32'(busy_o), 32'd1);
    k = 0;
    while (!bit_ready_o && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk("R3 accept latency", k, lag + SYNC);
    @(negedge clk);
    bit_valid = 1'b0;
    chk("R4 new idle line", 32'(drive_o), 32'(onehot(n)));
    chk("R3 idle after accept", 32'(busy_o), 32'd0);
    chk("R3 single ready pulse", 32'(bit_ready_o), 32'd0);
    cur = n;
  endtask

  // remote node hands the bus over from idle line c; DUT must end as master on c
  task automatic remote_yield(input int c, input logic poke);
    int n1, n2;
    n1 = (c + 1) % 3;
    n2 = (c + 2) % 3;
    rm_drv = onehot(n1);
    if (poke) begin
      repeat (SYNC) @(negedge clk);
      handover = 1'b1;
      bit_valid = 1'b1;
      bit_data = 1'b1;
      @(negedge clk);
      chk("R9 request beats handover and bit", 32'(drive_o), 32'(onehot(n2)));
      chk("R9 no accept on take", 32'(bit_ready_o), 32'd0);
      handover = 1'b0;
      bit_valid = 1'b0;
    end
    while (!lines[n2]) @(negedge clk);
    chk("R8 cross line driven", 32'(drive_o), 32'(onehot(n2)));
    chk("R8 not master while crossing", 32'(master_o), 32'd0);
    rm_drv = onehot(n2);
    while (!lines[c]) @(negedge clk);
    chk("R8 closing line driven", 32'(drive_o), 32'(onehot(c)));
    chk("R8 flag waits for lone line", 32'(master_o), 32'd0);
    rm_drv = onehot(c);
    while (!master_o) @(negedge clk);
    rm_drv = '0;
    @(negedge clk);
    chk("R8 master after take", 32'(master_o), 32'd1);
    chk("R8 idle after take", 32'(busy_o), 32'd0);
    chk("R9 back on old idle line", 32'(drive_o), 32'(onehot(c)));
  endtask

  task automatic remote_bit(input logic b);
    int n;
    n = b ? (cur + 1) % 3 : (cur + 2) % 3;
    rm_drv = onehot(n);
    while (lines[cur]) @(negedge clk);
    repeat (SYNC + 1) @(negedge clk);
    chk("R7 follows remote bit", 32'(drive_o), 32'(onehot(n)));
    chk("R7 follower settled", 32'(busy_o), 32'd0);
    cur = n;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    cur = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset drive", 32'(drive_o), 32'h1);
    chk("R1 reset master", 32'(master_o), 32'd1);
    chk("R1 reset busy", 32'(busy_o), 32'd0);
    chk("R1 reset ready", 32'(bit_ready_o), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 holds A after reset", 32'(drive_o), 32'h1);

    for (int v = 0; v < 8; v++)
      send_bit(VEC_TBL[v][3], int'(VEC_TBL[v][2:0]));
    chk("R4 rotation after table", cur, 2);

    // follower asks for service while DUT is master
    fol_lag = 0;
    remote_yield(cur, 1'b1);
    send_bit(1'b0, 1);

    // DUT gives the bus away; remote completes the rotation
    handover = 1'b1;
    @(negedge clk);
    handover = 1'b0;
    chk("R6 handover line", 32'(drive_o), 32'(onehot((cur + 1) % 3)));
    chk("R6 flag drops", 32'(master_o), 32'd0);
    while (!lines[(cur + 1) % 3]) @(negedge clk);
    rm_drv = onehot((cur + 2) % 3);
    while (lines != onehot((cur + 2) % 3)) @(negedge clk);
    chk("R7 follows handover step", 32'(drive_o), 32'(onehot((cur + 2) % 3)));
    rm_drv = onehot(cur);
    while (lines != onehot(cur)) @(negedge clk);
    repeat (SYNC + 1) @(negedge clk);
    chk("R7 back on idle line", 32'(drive_o), 32'(onehot(cur)));
    chk("R7 follower not master", 32'(master_o), 32'd0);
    chk("R7 follower settled", 32'(busy_o), 32'd0);

    remote_bit(1'b0);
    remote_bit(1'b1);

    // bits offered to a follower are ignored
    bit_valid = 1'b1;
    bit_data = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R5 follower drive unchanged", 32'(drive_o), 32'(onehot(cur)));
      chk("R5 no accept as follower", 32'(bit_ready_o), 32'd0);
    end
    bit_valid = 1'b0;

    // DUT claims the bus when the remote hands over
    claim = 1'b1;
    remote_yield(cur, 1'b0);
    claim = 1'b0;
    send_bit(1'b1, 2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule